// File: doc/BRIEF.md
# Audio Port Interrupt and Reset Controller

This block is the shared control point for two audio ports, A and B. Each port has an output direction and an input direction, so the block watches four FIFO request lines. A rising edge on a request line latches a status bit. Two per-direction enable masks gate the status bits: one for requests and one for errors. Together they drive a single CPU interrupt line. Software clears individual status bits by writing zeros to them. Separately, it re-arms the interrupt line by pulsing a dedicated interrupt-reset bit low and then high.

The same block owns the reset and clock-gating controls of both ports. A reset register holds one global reset bit, one reset bit per port and the interrupt-reset bit. All of them are active when 0, and software pulses them 0-then-1. A clock register holds one enable per port. Access is through a plain single-cycle register interface: a write strobe with an address and data, and read data that follows the address combinationally. There is no handshake, because every access completes in the cycle it is issued.

Register map (word index on `bus_addr`): 0 status, 1 request enable mask, 2 error enable mask, 3 reset control, 4 clock control. Indices 5 to 7 are unmapped.

Top module: `aud_irq_rst_ctrl`

## Requirements
- R1: After `rst_n` is released, the following hold:
  - status, both masks and clock control read 0;
  - reset control reads 0x1111;
  - `cpu_irq` is 0;
  - both `port_rst_n` bits are 1 and both `port_clk_en` bits are 0.
- R2: Status bit d (0 = A-out, 1 = A-in, 2 = B-out, 3 = B-in; `fifo_req[d]` uses the same bit) is set by the clock edge at which `fifo_req[d]` is first sampled high after being sampled low. A request held high does not set the bit again.
- R3: A write to status clears each bit written 0 and keeps each bit written 1. A set event in the same cycle as a clear wins.
- R4: `cpu_irq` is the OR over d of status[d] AND request-mask[d] AND error-mask[d] (mask bit d in position d), unless R5 blocks it.
- R5: Reset control bit 4 is the interrupt reset. In the cycle after it is 0, `cpu_irq` is 0. Once the bit returns to 1, `cpu_irq` stays 0 until a new status set event occurs.
- R6: Reset control bit 8 resets port A and bit 12 resets port B. While a port's bit is 0, the following hold:
  - that port's status bits (0 and 1 for A, 2 and 3 for B) clear on the next edge and stay 0;
  - its request edges are ignored;
  - its `port_rst_n` output is 0.
- R7: Reset control bit 0 is the global reset. While it is 0, the following hold:
  - status, both masks, clock control and the interrupt block return to their reset values on the next edge, and writes to them are ignored;
  - both `port_rst_n` and both `port_clk_en` outputs are 0;
  - reset control itself stays writable.
- R8: Clock control bit 0 drives `port_clk_en[0]` (port A) and bit 4 drives `port_clk_en[1]` (port B).
- R9: Bits without a function read as 0 in every register, and unmapped addresses read 0. Status bits 15..4, mask bits 15..4, reset control bits other than 0, 4, 8 and 12, and clock control bits other than 0 and 4 are all unassigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wen | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| fifo_req | input | 4 | FIFO request lines: A-out, A-in, B-out, B-in |
| cpu_irq | output | 1 | CPU interrupt, active high |
| port_rst_n | output | 2 | Active-low port resets: bit 0 port A, bit 1 port B |
| port_clk_en | output | 2 | Port clock enables: bit 0 port A, bit 1 port B |

## Verification
A wrong edge detector or a wrong status bit shows on `bus_rdata` at the status address on the cycle after the request edge. Whenever both masks are open, it also shows on `cpu_irq` in that same cycle. A stuck interrupt block appears as `cpu_irq` staying low after a fresh request edge once the interrupt-reset bit is back at 1. A missed global or port hold appears as non-zero mask or status readback one cycle after the reset bit reads 0. Because every register is visible on `bus_rdata`, each state error surfaces within one or two cycles of its cause.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;
  localparam int DIR_N        = 4;
  localparam int PORT_N       = 2;
  localparam int DIR_PER_PORT = DIR_N / PORT_N;

  // register word indices
  localparam int IDX_STATUS = 0;
  localparam int IDX_REQ_EN = 1;
  localparam int IDX_ERR_EN = 2;
  localparam int IDX_RESET  = 3;
  localparam int IDX_CLOCK  = 4;

  // reset control bit positions (active low)
  localparam int POS_GLOBAL    = 0;
  localparam int POS_IRQ_REARM = 4;
  localparam int POS_PORT_BASE = 8;
  localparam int POS_STRIDE    = 4;

  function automatic int port_rst_pos(input int p);
    return POS_PORT_BASE + POS_STRIDE * p;
  endfunction

  function automatic int port_clk_pos(input int p);
    return POS_STRIDE * p;
  endfunction
endpackage

// File: rtl/aud_rst_regs.sv
module aud_rst_regs
  import aud_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_rst,
  input  logic              wr_clk,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rst_bits,
  output logic [DATA_W-1:0] clk_bits,
  output logic              glob_ok,
  output logic              irq_armed,
  output logic [PORT_N-1:0] port_run,
  output logic [PORT_N-1:0] port_rst_n,
  output logic [PORT_N-1:0] port_clk_en
);
  function automatic logic [DATA_W-1:0] rst_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    m[POS_GLOBAL]    = 1'b1;
    m[POS_IRQ_REARM] = 1'b1;
    for (int p = 0; p < PORT_N; p++) m[port_rst_pos(p)] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] clk_mask_f();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int p = 0; p < PORT_N; p++) m[port_clk_pos(p)] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] RST_MASK = rst_mask_f();
  localparam logic [DATA_W-1:0] CLK_MASK = clk_mask_f();

  logic [DATA_W-1:0] rst_q;
  logic [DATA_W-1:0] clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rst_q <= RST_MASK;
    else if (wr_rst) rst_q <= wdata & RST_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                clk_q <= '0;
    else if (!rst_q[POS_GLOBAL]) clk_q <= '0;
    else if (wr_clk)           clk_q <= wdata & CLK_MASK;
  end

  assign glob_ok   = rst_q[POS_GLOBAL];
  assign irq_armed = rst_q[POS_IRQ_REARM];
  assign rst_bits  = rst_q;
  assign clk_bits  = clk_q;

  for (genvar p = 0; p < PORT_N; p++) begin : g_port
    assign port_run[p]    = rst_q[port_rst_pos(p)];
    assign port_rst_n[p]  = rst_q[port_rst_pos(p)] & glob_ok;
    assign port_clk_en[p] = clk_q[port_clk_pos(p)] & glob_ok;
  end
endmodule

// File: rtl/aud_req_status.sv
module aud_req_status
  import aud_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIR_N-1:0]  req,
  input  logic              glob_ok,
  input  logic [PORT_N-1:0] port_run,
  input  logic              clr_we,
  input  logic [DIR_N-1:0]  keep_bits,
  output logic [DIR_N-1:0]  stat,
  output logic [DIR_N-1:0]  set_ev
);
  logic [DIR_N-1:0] req_q;
  logic [DIR_N-1:0] stat_q;
  logic [DIR_N-1:0] stat_d;

  for (genvar d = 0; d < DIR_N; d++) begin : g_dir
    localparam int PORT = d / DIR_PER_PORT;
    logic held;
    assign set_ev[d] = req[d] & ~req_q[d] & glob_ok & port_run[PORT];
    assign held      = clr_we ? (stat_q[d] & keep_bits[d]) : stat_q[d];
    assign stat_d[d] = glob_ok & port_run[PORT] & (held | set_ev[d]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= '0;
      stat_q <= '0;
    end else begin
      req_q  <= req;
      stat_q <= stat_d;
    end
  end

  assign stat = stat_q;
endmodule

// File: rtl/aud_irq_gen.sv
module aud_irq_gen
  import aud_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glob_ok,
  input  logic             irq_armed,
  input  logic [DIR_N-1:0] set_ev,
  input  logic [DIR_N-1:0] stat,
  input  logic             wr_req_en,
  input  logic             wr_err_en,
  input  logic [DIR_N-1:0] wdata,
  output logic [DIR_N-1:0] req_en,
  output logic [DIR_N-1:0] err_en,
  output logic             cpu_irq
);
  logic [DIR_N-1:0] req_en_q;
  logic [DIR_N-1:0] err_en_q;
  logic             blocked_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_en_q  <= '0;
      err_en_q  <= '0;
      blocked_q <= 1'b0;
    end else if (!glob_ok) begin
      req_en_q  <= '0;
      err_en_q  <= '0;
      blocked_q <= 1'b0;
    end else begin
      if (wr_req_en) req_en_q <= wdata;
      if (wr_err_en) err_en_q <= wdata;
      if (!irq_armed)   blocked_q <= 1'b1;
      else if (|set_ev) blocked_q <= 1'b0;
    end
  end

  assign req_en  = req_en_q;
  assign err_en  = err_en_q;
  assign cpu_irq = ~blocked_q & (|(stat & req_en_q & err_en_q));
endmodule

// File: rtl/aud_irq_rst_ctrl.sv
module aud_irq_rst_ctrl
  import aud_irq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DIR_N-1:0]  fifo_req,
  output logic              cpu_irq,
  output logic [PORT_N-1:0] port_rst_n,
  output logic [PORT_N-1:0] port_clk_en
);
  localparam int PAD_W = DATA_W - DIR_N;

  logic              sel_status, sel_req_en, sel_err_en, sel_reset, sel_clock;
  logic [DATA_W-1:0] rst_bits, clk_bits;
  logic              glob_ok, irq_armed;
  logic [PORT_N-1:0] port_run;
  logic [DIR_N-1:0]  stat, set_ev, req_en, err_en;

  assign sel_status = (bus_addr == ADDR_W'(IDX_STATUS));
  assign sel_req_en = (bus_addr == ADDR_W'(IDX_REQ_EN));
  assign sel_err_en = (bus_addr == ADDR_W'(IDX_ERR_EN));
  assign sel_reset  = (bus_addr == ADDR_W'(IDX_RESET));
  assign sel_clock  = (bus_addr == ADDR_W'(IDX_CLOCK));

  aud_rst_regs #(.DATA_W(DATA_W)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_rst     (bus_wen & sel_reset),
    .wr_clk     (bus_wen & sel_clock),
    .wdata      (bus_wdata),
    .rst_bits   (rst_bits),
    .clk_bits   (clk_bits),
    .glob_ok    (glob_ok),
    .irq_armed  (irq_armed),
    .port_run   (port_run),
    .port_rst_n (port_rst_n),
    .port_clk_en(port_clk_en)
  );

  aud_req_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (fifo_req),
    .glob_ok  (glob_ok),
    .port_run (port_run),
    .clr_we   (bus_wen & sel_status),
    .keep_bits(bus_wdata[DIR_N-1:0]),
    .stat     (stat),
    .set_ev   (set_ev)
  );

  aud_irq_gen u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .glob_ok  (glob_ok),
    .irq_armed(irq_armed),
    .set_ev   (set_ev),
    .stat     (stat),
    .wr_req_en(bus_wen & sel_req_en),
    .wr_err_en(bus_wen & sel_err_en),
    .wdata    (bus_wdata[DIR_N-1:0]),
    .req_en   (req_en),
    .err_en   (err_en),
    .cpu_irq  (cpu_irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_status)      bus_rdata = {{PAD_W{1'b0}}, stat};
    else if (sel_req_en) bus_rdata = {{PAD_W{1'b0}}, req_en};
    else if (sel_err_en) bus_rdata = {{PAD_W{1'b0}}, err_en};
    else if (sel_reset)  bus_rdata = rst_bits;
    else if (sel_clock)  bus_rdata = clk_bits;
  end
endmodule

// File: rtl/aud_irq_rst_ctrl_chk.sv
module aud_irq_rst_ctrl_chk
  import aud_irq_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DIR_N-1:0]  fifo_req,
  input logic [DATA_W-1:0] rst_bits,
  input logic [DIR_N-1:0]  stat,
  input logic [DIR_N-1:0]  req_en,
  input logic [DIR_N-1:0]  err_en,
  input logic              cpu_irq
);
  // R2
  a_out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_bits[0] && rst_bits[8] && fifo_req[0] && !$past(fifo_req[0])) |=> stat[0]);

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> ((stat & req_en & err_en) != '0));

  // R5
  irq_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_bits[4] |=> !cpu_irq);

  // R6
  port_b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_bits[12] |=> (stat[3:2] == 2'b00));

  // R7
  global_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_bits[0] |=> (stat == '0 && req_en == '0 && err_en == '0 && !cpu_irq));
endmodule

bind aud_irq_rst_ctrl aud_irq_rst_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fifo_req(fifo_req),
  .rst_bits(rst_bits),
  .stat    (stat),
  .req_en  (req_en),
  .err_en  (err_en),
  .cpu_irq (cpu_irq)
);

// File: tb/aud_irq_rst_ctrl_bench.sv
`timescale 1ns/100ps
module aud_irq_rst_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [3:0]  fifo_req = '0;
  logic        cpu_irq;
  logic [1:0]  port_rst_n;
  logic [1:0]  port_clk_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aud_irq_rst_ctrl u_aud_irq_rst_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_req(fifo_req),
    .cpu_irq(cpu_irq), .port_rst_n(port_rst_n), .port_clk_en(port_clk_en)
  );

  // behavioural reference state
  int m_stat, m_ren, m_een, m_rst, m_clk, m_reqq;
  bit m_blk;

  function automatic int model_read(input int a);
    case (a)
      0: return m_stat;
      1: return m_ren;
      2: return m_een;
      3: return m_rst;
      4: return m_clk;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_ren = 0; m_een = 0; m_rst = 'h1111; m_clk = 0; m_reqq = 0; m_blk = 0;
    end else begin
      bit g, ar, br, ir;
      int ev, s;
      g = m_rst[0]; ir = m_rst[4]; ar = m_rst[8]; br = m_rst[12];
      ev = 0;
      for (int d = 0; d < 4; d++)
        if (fifo_req[d] && !m_reqq[d] && g && ((d < 2) ? ar : br)) ev |= (1 << d);
      if (!g) begin
        m_stat = 0; m_ren = 0; m_een = 0; m_clk = 0; m_blk = 0;
      end else begin
        s = m_stat;
        if (bus_wen && bus_addr == 0) s &= bus_wdata[3:0];
        s |= ev;
        if (!ar) s &= 'hC;
        if (!br) s &= 'h3;
        m_stat = s;
        if (bus_wen && bus_addr == 1) m_ren = bus_wdata[3:0];
        if (bus_wen && bus_addr == 2) m_een = bus_wdata[3:0];
        if (bus_wen && bus_addr == 4) m_clk = bus_wdata & 'h0011;
        if (!ir) m_blk = 1;
        else if (ev != 0) m_blk = 0;
      end
      if (bus_wen && bus_addr == 3) m_rst = bus_wdata & 'h1111;
      m_reqq = fifo_req;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      bit g;
      bit exp_irq;
      int exp_rn, exp_ce;
      g = m_rst[0];
      exp_irq = !m_blk && ((m_stat & m_ren & m_een) != 0);
      exp_rn = {m_rst[12] & g, m_rst[8] & g};
      exp_ce = {m_clk[4] & g, m_clk[0] & g};
      check(cpu_irq == exp_irq, "R4 cpu_irq vs model", cpu_irq, exp_irq);
      check(port_rst_n == exp_rn[1:0], "R6 port_rst_n vs model", port_rst_n, exp_rn);
      check(port_clk_en == exp_ce[1:0], "R8 port_clk_en vs model", port_clk_en, exp_ce);
      check(bus_rdata == model_read(bus_addr), "R9 bus_rdata vs model", bus_rdata, model_read(bus_addr));
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); #1;
    bus_wen = 1'b1; bus_addr = a[2:0]; bus_wdata = d[15:0];
    @(negedge clk); #1;
    bus_wen = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string tag);
    @(negedge clk); #1;
    bus_addr = a[2:0];
    #1;
    check(bus_rdata == exp[15:0], tag, bus_rdata, exp);
  endtask

  task automatic irq_chk(input bit exp, input string tag);
    @(negedge clk); #1;
    check(cpu_irq == exp, tag, cpu_irq, exp);
  endtask

  task automatic set_req(input int v);
    @(negedge clk); #1;
    fifo_req = v[3:0];
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd_chk(0, 0, "R1 status after reset");
    rd_chk(1, 0, "R1 req mask after reset");
    rd_chk(2, 0, "R1 err mask after reset");
    rd_chk(3, 'h1111, "R1 reset ctl after reset");
    rd_chk(4, 0, "R1 clock ctl after reset");
    check(port_rst_n == 2'b11, "R1 port_rst_n", port_rst_n, 3);
    check(port_clk_en == 2'b00, "R1 port_clk_en", port_clk_en, 0);
    irq_chk(0, "R1 cpu_irq after reset");

    wr(1, 'hF); wr(2, 'hF);
    // R2 edge sets status
    set_req('b0001);
    rd_chk(0, 'h1, "R2 A-out edge sets bit 0");
    irq_chk(1, "R4 irq with both masks open");
    set_req(0);
    // R3 clear by writing zero
    wr(0, 'hFFFE);
    rd_chk(0, 0, "R3 write-zero clears");
    // R2 held level does not re-set
    set_req('b0010);
    rd_chk(0, 'h2, "R2 A-in edge sets bit 1");
    wr(0, 'hFFFD);
    repeat (3) @(negedge clk);
    rd_chk(0, 0, "R2 held request does not re-set");
    set_req(0);
    // R3 set wins over same-cycle clear
    @(negedge clk); #1;
    fifo_req = 4'b0100; bus_wen = 1'b1; bus_addr = 3'd0; bus_wdata = 16'h0000;
    @(negedge clk); #1;
    bus_wen = 1'b0;
    rd_chk(0, 'h4, "R3 set wins over clear");
    // R4 mask combinations
    wr(2, 'hB);
    irq_chk(0, "R4 err mask closed");
    wr(1, 'h4); wr(2, 'h4);
    irq_chk(1, "R4 single bit both masks");
    wr(1, 0);
    irq_chk(0, "R4 req mask closed");
    wr(1, 'hF); wr(2, 'hF);
    irq_chk(1, "R4 masks reopened");
    // R5 interrupt re-arm
    wr(3, 'h1101);
    irq_chk(0, "R5 irq low while rearm bit 0");
    wr(3, 'h1111);
    irq_chk(0, "R5 irq stays low after rearm");
    rd_chk(0, 'h4, "R5 status kept by rearm");
    set_req(0);
    set_req('b1000);
    rd_chk(0, 'hC, "R5 new edge sets bit 3");
    irq_chk(1, "R5 irq returns on new event");
    set_req(0);
    // R6 port resets
    wr(3, 'h0111);
    rd_chk(0, 0, "R6 port B reset clears B bits");
    check(port_rst_n == 2'b01, "R6 port B reset output", port_rst_n, 1);
    set_req('b1001);
    rd_chk(0, 'h1, "R6 B edge ignored, A edge kept");
    set_req(0);
    wr(3, 'h1011);
    rd_chk(0, 0, "R6 port A reset clears A bits");
    wr(3, 'h1111);
    // R7 global reset
    wr(3, 'h1110);
    rd_chk(1, 0, "R7 req mask held");
    rd_chk(2, 0, "R7 err mask held");
    wr(1, 'hF);
    rd_chk(1, 0, "R7 mask write ignored");
    set_req('b0100);
    rd_chk(0, 0, "R7 request ignored");
    check(port_rst_n == 2'b00, "R7 port_rst_n low", port_rst_n, 0);
    rd_chk(3, 'h1110, "R7 reset ctl writable");
    set_req(0);
    wr(3, 'h1111);
    // R8 clock enables
    wr(4, 'h0001);
    check(port_clk_en == 2'b01, "R8 port A clock", port_clk_en, 1);
    wr(4, 'h0010);
    check(port_clk_en == 2'b10, "R8 port B clock", port_clk_en, 2);
    // R9 unassigned bits and addresses
    wr(4, 'hFFFF);
    rd_chk(4, 'h0011, "R9 clock ctl spare bits");
    wr(3, 'hFFFF);
    rd_chk(3, 'h1111, "R9 reset ctl spare bits");
    wr(1, 'hFFFF);
    rd_chk(1, 'hF, "R9 mask spare bits");
    set_req('hF);
    rd_chk(0, 'hF, "R9 status spare bits");
    rd_chk(5, 0, "R9 unmapped 5");
    rd_chk(6, 0, "R9 unmapped 6");
    rd_chk(7, 0, "R9 unmapped 7");
    set_req(0);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule